// File: doc/BRIEF.md
# Video Port Write FIFO Scheduler

This block models when a video processor's write path is able to accept more data from a CPU. It does not move any data. It keeps a short queue of typed burst descriptors. A descriptor is a CPU data-port write, a foreground DMA burst, or a background DMA burst (copy or fill). One access slot of work is retired for each slot strobe that a separate slot generator sends. From the number of pending words the block derives a CPU stall, FIFO full and empty status, a transfer-active flag and a DMA-busy flag.

Bursts of the same kind merge into the last descriptor. A CPU write always moves ahead of a background DMA burst, which stays last in the queue. A byte-mode burst uses two access slots for each word. A CPU data-port read stalls until the whole queue, background DMA included, has drained, and then stalls for one more access slot. The line-start strobe resets the slot position and leaves any unfinished burst to continue on the next line.

There is no back-pressure on the request port. Every request is a single-cycle strobe. The CPU is expected to honour `cpu_wait`. A request that arrives while every descriptor is occupied is dropped and reported on `req_dropped`.

Top module: `vpf_sched`

## Requirements
- R1: After reset, `fifo_empty`=1, `fifo_full`=0, `cpu_wait`=0, `xfer_active`=0, `dma_busy`=0, `req_dropped`=0 and `slot_pos`=0.
- R2: The pending total is the sum of the queued words of every descriptor that is not background DMA. `fifo_full` is 1 when this total is 4 or more. `fifo_empty` is 1 when it is 0.
- R3: `cpu_wait` is 1 while the pending total is greater than 4. It stays 1 while a read is waiting (see R8).
- R4: When a request enters an idle queue, the first 3 slot strobes that follow retire nothing. Each later strobe retires one slot.
- R5: A word-mode descriptor (`req_byte`=0) takes one slot for each word. A byte-mode descriptor (`req_byte`=1) takes two slots for each word, and its word leaves the pending total on the second of them.
- R6: A request merges into the last non-background descriptor when transfers are running and its kind bits {byte, background, foreground} are equal to that descriptor's. A merged request uses no new queue entry.
- R7: A non-background request that arrives while a background DMA descriptor is last in the queue is placed ahead of it. If the background descriptor is being serviced, its remaining words (remaining slots shifted right by its byte bit) move back one place, and the new request is serviced first after the R4 latency.
- R8: A `rd_req` pulse holds `cpu_wait` at 1 until a slot strobe arrives while the queue holds no descriptor at all.
- R9: `line_start` sets `slot_pos` to 0 in the following cycle. Each slot strobe without `line_start` adds 1. Queued work is not affected and keeps retiring on the next line.
- R10: When the last descriptor retires, `xfer_active` clears. `dma_busy`, which any DMA request sets, clears at the same moment unless `fill_arm` is 1.
- R11: A slot strobe while no transfer is active changes no queue state. A later request still sees the full R4 latency.
- R12: A request that needs a new entry while all 8 entries are occupied is dropped. The pending total does not change, and `req_dropped` is 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle transfer request strobe |
| req_count | input | REQ_W | Words in the request (0 is ignored) |
| req_byte | input | 1 | Request is byte mode (two slots per word) |
| req_bg | input | 1 | Request is background DMA (copy or fill) |
| req_fg | input | 1 | Request is foreground DMA |
| rd_req | input | 1 | CPU data-port read strobe |
| fill_arm | input | 1 | A DMA fill is armed; keeps `dma_busy` set |
| line_start | input | 1 | Start-of-line strobe |
| slot_strobe | input | 1 | One access slot has passed |
| cpu_wait | output | 1 | Stall the CPU |
| fifo_full | output | 1 | Pending total is 4 or more |
| fifo_empty | output | 1 | Pending total is 0 |
| xfer_active | output | 1 | Some descriptor is queued |
| dma_busy | output | 1 | A DMA transfer is in progress or a fill is armed |
| req_dropped | output | 1 | The previous request was lost to a full queue |
| slot_pos | output | POS_W | Slot strobes counted since the last line start |

## Verification
The assertions assume that each strobe input stays high for one cycle per event. They also assume that the requests and strobes do not push the descriptor word counts past their width. The stimulus drives every request, read, slot and line-start pulse for exactly one clock. It keeps each burst to a few words, so no count gets near wrapping. It never raises a request and a slot strobe in the same cycle. That keeps the expected pending total a simple running sum that the bench tracks step by step.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam int ECNT_W = 12;

  typedef struct packed {
    logic [ECNT_W-1:0] cnt;
    logic              byt;
    logic              bg;
    logic              fg;
  } desc_t;

  function automatic logic [2:0] desc_kind(desc_t d);
    return {d.byt, d.bg, d.fg};
  endfunction
endpackage

// File: rtl/vpf_slot_pos.sv
module vpf_slot_pos #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             slot_strobe,
  output logic [POS_W-1:0] slot_pos
);
  always_ff @(posedge clk) begin
    if (!rst_n)          slot_pos <= '0;
    else if (line_start) slot_pos <= '0;
    else if (slot_strobe) slot_pos <= slot_pos + 1'b1;
  end
endmodule

// File: rtl/vpf_read_gate.sv
module vpf_read_gate #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             slot_strobe,
  input  logic [LEN_W-1:0] q_len,
  output logic             rd_pend
);
  logic release_now;
  assign release_now = slot_strobe && (q_len == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= rd_req || (rd_pend && !release_now);
  end
endmodule

// File: rtl/vpf_status.sv
module vpf_status #(
  parameter int TOT_W     = 16,
  parameter int STALL_LVL = 4
) (
  input  logic [TOT_W-1:0] total,
  input  logic             rd_pend,
  output logic             cpu_wait,
  output logic             fifo_full,
  output logic             fifo_empty
);
  localparam logic [TOT_W-1:0] LVL = TOT_W'(STALL_LVL);

  assign fifo_full  = (total >= LVL);
  assign fifo_empty = (total == '0);
  assign cpu_wait   = (total > LVL) || rd_pend;
endmodule

// File: rtl/vpf_sched.sv
module vpf_sched #(
  parameter int DEPTH     = 8,
  parameter int REQ_W     = 8,
  parameter int LAT       = 3,
  parameter int STALL_LVL = 4,
  parameter int POS_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_count,
  input  logic             req_byte,
  input  logic             req_bg,
  input  logic             req_fg,
  input  logic             rd_req,
  input  logic             fill_arm,
  input  logic             line_start,
  input  logic             slot_strobe,
  output logic             cpu_wait,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             xfer_active,
  output logic             dma_busy,
  output logic             req_dropped,
  output logic [POS_W-1:0] slot_pos
);
  import vpf_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = PTR_W + 1;
  localparam int ACT_W = ECNT_W + 1;
  localparam int TOT_W = ECNT_W + PTR_W;
  localparam int LAT_W = $clog2(LAT + 1);

  desc_t            q   [DEPTH];
  desc_t            n_q [DEPTH];
  logic [PTR_W-1:0] head, n_head;
  logic [LEN_W-1:0] q_len, n_len;
  logic [ACT_W-1:0] act, n_act;
  logic [TOT_W-1:0] total, n_tot;
  logic [LAT_W-1:0] lat, n_lat;
  logic             run, n_run, n_busy, n_drop;
  logic             rd_pend;

  desc_t            hd, nd, moved;
  logic [PTR_W-1:0] tail, tgt;
  logic             tail_bg;

  always_comb begin
    n_q    = q;
    n_head = head;
    n_len  = q_len;
    n_act  = act;
    n_tot  = total;
    n_lat  = lat;
    n_run  = run;
    n_busy = dma_busy;
    n_drop = 1'b0;
    hd     = q[head];
    nd     = '{cnt: ECNT_W'(req_count), byt: req_byte, bg: req_bg, fg: req_fg};
    moved  = '0;
    tail   = '0;
    tgt    = '0;
    tail_bg = 1'b0;

    // retire one access slot
    if (slot_strobe && run) begin
      if (lat != '0) begin
        n_lat = lat - 1'b1;
      end else begin
        if (!hd.bg && (!hd.byt || act[0])) n_tot = n_tot - 1'b1;
        n_act = act - 1'b1;
        if (n_act == '0) begin
          n_q[head] = '0;
          n_head    = head + 1'b1;
          n_len     = q_len - 1'b1;
          if (n_len != '0) begin
            n_act = ACT_W'(q[n_head].cnt) << q[n_head].byt;
          end else begin
            n_run = 1'b0;
            n_tot = '0;
            if (!fill_arm) n_busy = 1'b0;
          end
        end
      end
    end

    // accept a request
    if (req_valid && req_count != '0) begin
      if (n_len == LEN_W'(DEPTH)) begin
        n_drop = 1'b1;
      end else begin
        tail    = n_head + PTR_W'(n_len) - 1'b1;
        tail_bg = (n_len != '0) && n_q[tail].bg && !req_bg;
        if (tail_bg && n_len == LEN_W'(1)) begin
          // overtake a background burst that is being serviced
          moved           = n_q[tail];
          moved.cnt       = ECNT_W'(n_act >> moved.byt);
          n_q[tail + 1'b1] = moved;
          n_q[tail]       = nd;
          n_len           = LEN_W'(2);
          n_run           = 1'b1;
          n_lat           = LAT_W'(LAT);
          n_act           = ACT_W'(nd.cnt) << nd.byt;
        end else begin
          tgt = tail_bg ? tail - 1'b1 : tail;
          if (n_run && n_len != '0 && desc_kind(n_q[tgt]) == desc_kind(nd)) begin
            n_q[tgt].cnt = n_q[tgt].cnt + nd.cnt;
            if (tgt == n_head) n_act = n_act + (ACT_W'(nd.cnt) << nd.byt);
          end else begin
            if (tail_bg) begin
              n_q[tail + 1'b1] = n_q[tail];
              n_q[tail]        = nd;
            end else begin
              n_q[tail + 1'b1] = nd;
            end
            n_len = n_len + 1'b1;
            if (!n_run) begin
              n_run = 1'b1;
              n_lat = LAT_W'(LAT);
              n_act = ACT_W'(nd.cnt) << nd.byt;
            end
          end
        end
        if (!req_bg) n_tot = n_tot + TOT_W'(req_count);
        if (req_bg || req_fg) n_busy = 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) q[gi] <= '0;
      else        q[gi] <= n_q[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head        <= '0;
      q_len       <= '0;
      act         <= '0;
      total       <= '0;
      lat         <= '0;
      run         <= 1'b0;
      dma_busy    <= 1'b0;
      req_dropped <= 1'b0;
    end else begin
      head        <= n_head;
      q_len       <= n_len;
      act         <= n_act;
      total       <= n_tot;
      lat         <= n_lat;
      run         <= n_run;
      dma_busy    <= n_busy;
      req_dropped <= n_drop;
    end
  end

  assign xfer_active = run;

  vpf_slot_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .slot_strobe(slot_strobe), .slot_pos(slot_pos)
  );

  vpf_read_gate #(.LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .slot_strobe(slot_strobe), .q_len(q_len), .rd_pend(rd_pend)
  );

  vpf_status #(.TOT_W(TOT_W), .STALL_LVL(STALL_LVL)) u_stat (
    .total(total), .rd_pend(rd_pend), .cpu_wait(cpu_wait),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );
endmodule

// File: rtl/vpf_sched_chk.sv
module vpf_sched_chk #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 4,
  parameter int POS_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             line_start,
  input logic             slot_strobe,
  input logic             cpu_wait,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             xfer_active,
  input logic             req_dropped,
  input logic             rd_pend,
  input logic [LEN_W-1:0] q_len,
  input logic [POS_W-1:0] slot_pos
);
  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  assert_wait_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (fifo_full || rd_pend));

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_len <= LEN_W'(DEPTH));

  assert_line_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (slot_pos == '0));

  assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> fifo_empty);

  assert_idle_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && !xfer_active && !req_valid) |=> (!xfer_active && fifo_empty));

  assert_drop_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_dropped |-> ($past(q_len) == LEN_W'(DEPTH)));
endmodule

bind vpf_sched vpf_sched_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .POS_W(POS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .line_start(line_start),
  .slot_strobe(slot_strobe), .cpu_wait(cpu_wait), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .xfer_active(xfer_active), .req_dropped(req_dropped),
  .rd_pend(rd_pend), .q_len(q_len), .slot_pos(slot_pos)
);

// File: tb/vpf_sched_tb.sv
module vpf_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_count = '0;
  logic       req_byte = 1'b0, req_bg = 1'b0, req_fg = 1'b0;
  logic       rd_req = 1'b0, fill_arm = 1'b0, line_start = 1'b0, slot_strobe = 1'b0;
  logic       cpu_wait, fifo_full, fifo_empty, xfer_active, dma_busy, req_dropped;
  logic [8:0] slot_pos;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vpf_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
    .req_byte(req_byte), .req_bg(req_bg), .req_fg(req_fg), .rd_req(rd_req),
    .fill_arm(fill_arm), .line_start(line_start), .slot_strobe(slot_strobe),
    .cpu_wait(cpu_wait), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .xfer_active(xfer_active), .dma_busy(dma_busy), .req_dropped(req_dropped),
    .slot_pos(slot_pos)
  );

  // {op[1:0], empty, full, wait, active}; op 0 strobe, 1 word write, 2 byte write
  localparam logic [5:0] VEC [19] = '{
    {2'd1, 4'b0001},  // R2 total 1
    {2'd1, 4'b0001},  // R6 merge, total 2
    {2'd1, 4'b0001},  // total 3
    {2'd1, 4'b0101},  // R2 full at 4
    {2'd1, 4'b0111},  // R3 wait at 5
    {2'd0, 4'b0111},  // R4 latency 1
    {2'd0, 4'b0111},  // R4 latency 2
    {2'd0, 4'b0111},  // R4 latency 3
    {2'd0, 4'b0101},  // R3 first retire, total 4
    {2'd0, 4'b0001},
    {2'd0, 4'b0001},
    {2'd0, 4'b0001},
    {2'd0, 4'b1000},  // R10 drained
    {2'd2, 4'b0001},  // R5 byte word
    {2'd0, 4'b0001},
    {2'd0, 4'b0001},
    {2'd0, 4'b0001},
    {2'd0, 4'b0001},  // R5 first slot keeps word
    {2'd0, 4'b1000}   // R5 second slot retires it
  };

  task automatic check(input logic [8:0] got, input logic [8:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic req(input int cnt, input logic byt, input logic bg, input logic fg);
    req_valid = 1'b1; req_count = 8'(cnt); req_byte = byt; req_bg = bg; req_fg = fg;
    @(posedge clk); #5;
    req_valid = 1'b0; req_count = '0; req_byte = 1'b0; req_bg = 1'b0; req_fg = 1'b0;
  endtask

  task automatic strobe(input int n);
    for (int k = 0; k < n; k++) begin
      slot_strobe = 1'b1;
      @(posedge clk); #5;
      slot_strobe = 1'b0;
    end
  endtask

  task automatic pulse_line();
    line_start = 1'b1; @(posedge clk); #5; line_start = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_req = 1'b1; @(posedge clk); #5; rd_req = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 reset state
    check(fifo_empty, 1, "R1 empty");
    check(fifo_full, 0, "R1 full");
    check(cpu_wait, 0, "R1 wait");
    check(xfer_active, 0, "R1 active");
    check(dma_busy, 0, "R1 busy");
    check(req_dropped, 0, "R1 dropped");
    check(slot_pos, 0, "R1 pos");

    // table: R2 R3 R4 R5 with word merge
    for (int i = 0; i < 19; i++) begin
      logic [5:0] v;
      v = VEC[i];
      if (v[5:4] == 2'd0) strobe(1);
      else req(1, v[5:4] == 2'd2, 1'b0, 1'b0);
      check(fifo_empty, v[3], $sformatf("R2 vec%0d empty", i));
      check(fifo_full, v[2], $sformatf("R2 vec%0d full", i));
      check(cpu_wait, v[1], $sformatf("R3 vec%0d wait", i));
      check(xfer_active, v[0], $sformatf("R4 vec%0d active", i));
    end

    // R11 strobes while idle, R9 slot position
    pulse_line();
    check(slot_pos, 0, "R9 pos after line");
    strobe(5);
    check(slot_pos, 5, "R9 pos count");
    check(xfer_active, 0, "R11 idle strobe active");
    check(fifo_empty, 1, "R11 idle strobe empty");
    req(1, 0, 0, 0);
    strobe(3);
    check(fifo_empty, 0, "R11 latency intact");
    pulse_line();
    check(slot_pos, 0, "R9 line reset");
    strobe(1);
    check(fifo_empty, 1, "R9 carry-over retire");
    check(slot_pos, 1, "R9 pos after strobe");

    // R8 read waits for drain plus one slot
    req(1, 0, 0, 0);
    pulse_rd();
    check(cpu_wait, 1, "R8 read wait");
    strobe(4);
    check(fifo_empty, 1, "R8 drained");
    check(cpu_wait, 1, "R8 wait through drain slot");
    strobe(1);
    check(cpu_wait, 0, "R8 released");
    pulse_rd();
    check(cpu_wait, 1, "R8 idle read wait");
    strobe(1);
    check(cpu_wait, 0, "R8 idle read released");

    // R6 nine same-kind writes merge without drop
    for (int i = 0; i < 9; i++) begin
      req(1, 0, 0, 0);
      check(req_dropped, 0, "R6 merge no drop");
    end
    check(cpu_wait, 1, "R6 wait with 9");
    strobe(11);
    check(fifo_empty, 0, "R6 one left");
    strobe(1);
    check(fifo_empty, 1, "R6 drained");

    // R12 alternating kinds fill 8 entries, ninth dropped
    for (int i = 0; i < 8; i++) req(1, i[0], 0, 0);
    check(req_dropped, 0, "R12 no drop at 8");
    req(1, 0, 0, 0);
    check(req_dropped, 1, "R12 drop flag");
    check(fifo_full, 1, "R12 total kept full");
    strobe(1);
    check(req_dropped, 0, "R12 drop one cycle");
    strobe(13);
    check(fifo_empty, 0, "R12 total was 8");
    strobe(1);
    check(fifo_empty, 1, "R12 drained at 15");

    // R7 CPU write overtakes running background burst
    req(4, 1, 1, 0);
    check(fifo_empty, 1, "R7 bg not counted");
    check(xfer_active, 1, "R7 bg active");
    check(dma_busy, 1, "R7 busy");
    strobe(5);
    req(1, 0, 0, 0);
    check(fifo_empty, 0, "R7 cpu queued");
    strobe(3);
    check(fifo_empty, 0, "R7 cpu latency");
    strobe(1);
    check(fifo_empty, 1, "R7 cpu first");
    check(xfer_active, 1, "R7 bg resumes");
    strobe(5);
    check(xfer_active, 1, "R7 bg remaining");
    strobe(1);
    check(xfer_active, 0, "R7 bg done");
    check(dma_busy, 0, "R10 busy clears");

    // R10 armed fill keeps busy
    fill_arm = 1'b1;
    req(2, 0, 0, 1);
    check(dma_busy, 1, "R10 fg busy");
    strobe(5);
    check(xfer_active, 0, "R10 active clears");
    check(dma_busy, 1, "R10 busy held by fill");
    fill_arm = 1'b0;
    req(1, 0, 0, 0);
    strobe(4);
    check(dma_busy, 0, "R10 busy clears unarmed");

    summary();
  end
endmodule